// File: doc/BRIEF.md
# Nested Four-Level Interrupt Arbiter

This block selects which of seven interrupt sources a small 8-bit controller core should service next. The sources are two external pins, three timer overflows, a serial port and a counter-array unit. Software programs an enable register, with one global gate and one bit per source, and two priority registers. For each source, the two priority bits together form a level from 0 (lowest) to 3 (highest).

The arbiter keeps one in-service flag per level. It raises a registered vector request, carrying a source index, only when an enabled pending source has a level strictly above the highest level currently in service. The core acknowledges the request, which marks that level as in service. A return pulse from the core releases the highest level in service. Requests that are blocked are not latched. They win later if they are still asserted when the blocking level is released.

Top module: `irq_nest_arb`

## Requirements
- R1: Enable register layout (`cfg_sel`=0): bit 7 is the global gate. Bits 6..0 enable counter array, timer 2, serial, timer 1, external 1, timer 0 and external 0. A source's index on `src_req` and `vec_idx` equals its enable bit position (0 = external 0 ... 6 = counter array).
- R2: After reset all enables and priorities are zero and no level is in service, so no request is raised even with every source asserted.
- R3: While the global gate is clear, no request is raised. While it is set, a source can win only if its own enable bit is set.
- R4: A source's level is {bit i of the high priority register (`cfg_sel`=2), bit i of the low priority register (`cfg_sel`=1)}. Among eligible simultaneous requests, the highest level wins.
- R5: Among eligible requests at the same level, the lowest index wins. The polling order is therefore external 0, timer 0, external 1, timer 1, serial, timer 2, counter array.
- R6: A request is eligible only if its level is strictly above the highest level in service. Equal or lower levels wait, and nothing preempts level 3.
- R7: `vec_req` and `vec_idx` are registered. They appear one clock after the inputs are sampled, stay stable until `vec_ack`, and `vec_req` drops on the clock that samples `vec_ack`.
- R8: An acknowledge marks the granted level as in service. A `reti` pulse clears only the highest level in service, and lower nested levels stay in service.
- R9: A blocked request that is still asserted and enabled is raised on the clock after `reti` releases the blocking level.
- R10: A write with `cfg_sel`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 low priority, 2 high priority, 3 none |
| cfg_wdata | input | 8 | Register write data |
| src_req | input | 7 | Level request from each source |
| vec_ack | input | 1 | Core accepts the raised vector |
| reti | input | 1 | Return pulse, releases the highest level in service |
| vec_req | output | 1 | Vector request to the core |
| vec_idx | output | 3 | Index of the requesting source |

## Verification
The hardest states to reach are nested service states, where two or more in-service flags are set at once and a single return must release only the top one. The bench builds them from the ports. It raises and acknowledges a low-level source, then raises and acknowledges a higher one, then issues one return. It then probes the remaining state with requests just below and just above the surviving level. A full sweep of every in-service level against every source level covers the strict preemption rule, including level 3 blocking all sources.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int CFG_SEL_W = 2;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_PRIO_LO = 2'd1,
    SEL_PRIO_HI = 2'd2,
    SEL_NONE    = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int LVL_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CFG_SEL_W-1:0]             cfg_sel,
  input  logic [NUM_SRC:0]                 cfg_wdata,
  output logic                             glb_en,
  output logic [NUM_SRC-1:0]               src_en,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    src_lvl
);
  localparam int REG_W = NUM_SRC + 1;

  logic [REG_W-1:0]              en_q;
  logic                          en_ld;
  logic [LVL_W-1:0][NUM_SRC-1:0] prio_q;
  logic [LVL_W-1:0]              prio_ld;

  // load enables
  always_comb begin
    en_ld = cfg_we && (cfg_sel == SEL_ENABLE);
    for (int b = 0; b < LVL_W; b++) begin
      prio_ld[b] = cfg_we && (cfg_sel == CFG_SEL_W'(b + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ld) begin
      en_q <= cfg_wdata;
    end
  end

  for (genvar b = 0; b < LVL_W; b++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[b] <= '0;
      end else if (prio_ld[b]) begin
        prio_q[b] <= cfg_wdata[NUM_SRC-1:0];
      end
    end
  end

  assign glb_en = en_q[NUM_SRC];
  assign src_en = en_q[NUM_SRC-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    for (genvar b = 0; b < LVL_W; b++) begin : g_bit
      assign src_lvl[i][b] = prio_q[b][i];
    end
  end

  AST_RSVD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_NONE) |=> ($stable(en_q) && $stable(prio_q))); // R10
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int NUM_SRC = 7,
  parameter int LVL_W   = 2
) (
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl,
  input  logic                           floor_vld,
  input  logic [LVL_W-1:0]               floor_lvl,
  output logic                           win_vld,
  output logic [$clog2(NUM_SRC)-1:0]     win_idx,
  output logic [LVL_W-1:0]               win_lvl
);
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_hit;

  // a source counts at its level only if that level beats the floor
  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lv
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign lvl_hit[lv][i] = cand[i] && (src_lvl[i] == LVL_W'(lv)) &&
                              (!floor_vld || (LVL_W'(lv) > floor_lvl));
    end
  end

  always_comb begin
    win_vld = 1'b0;
    win_lvl = '0;
    for (int lv = 0; lv < NUM_LVL; lv++) begin
      if (|lvl_hit[lv]) begin
        win_vld = 1'b1;
        win_lvl = LVL_W'(lv);
      end
    end
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (lvl_hit[win_lvl][i]) begin
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
  parameter int LVL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      grant,
  input  logic [LVL_W-1:0]          grant_lvl,
  input  logic                      reti,
  output logic                      top_vld,
  output logic [LVL_W-1:0]          top_lvl
);
  localparam int NUM_LVL = 1 << LVL_W;

  logic [NUM_LVL-1:0] svc_q;
  logic [NUM_LVL-1:0] svc_d;
  logic               svc_ld;

  always_comb begin
    top_vld = |svc_q;
    top_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (svc_q[l]) top_lvl = LVL_W'(l);
    end
  end

  // pop first, then push, so a same-cycle grant always survives
  always_comb begin
    svc_d  = svc_q;
    svc_ld = reti || grant;
    if (reti && top_vld) svc_d[top_lvl] = 1'b0;
    if (grant)           svc_d[grant_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= '0;
    end else if (svc_ld) begin
      svc_q <= svc_d;
    end
  end

  AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !grant && (|svc_q)) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1)); // R8
  AST_GRANT_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> svc_q[$past(grant_lvl)]); // R8
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int LVL_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_sel,
  input  logic [NUM_SRC:0]             cfg_wdata,
  input  logic [NUM_SRC-1:0]           src_req,
  input  logic                         vec_ack,
  input  logic                         reti,
  output logic                         vec_req,
  output logic [$clog2(NUM_SRC)-1:0]   vec_idx
);
  localparam int IDX_W = $clog2(NUM_SRC);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic                          glb_en;
  logic [NUM_SRC-1:0]            src_en;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [NUM_SRC-1:0]            cand;
  logic                          top_vld;
  logic [LVL_W-1:0]              top_lvl;
  logic                          win_vld;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .glb_en    (glb_en),
    .src_en    (src_en),
    .src_lvl   (src_lvl)
  );

  assign cand = src_req & src_en & {NUM_SRC{glb_en}};

  irq_level_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
    .cand      (cand),
    .src_lvl   (src_lvl),
    .floor_vld (top_vld),
    .floor_lvl (top_lvl),
    .win_vld   (win_vld),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  logic             req_q, req_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             raise, grant, req_ld;

  assign raise = !req_q && win_vld;
  assign grant = req_q && vec_ack;

  irq_svc_stack #(.LVL_W(LVL_W)) u_svc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .grant     (grant),
    .grant_lvl (lvl_q),
    .reti      (reti),
    .top_vld   (top_vld),
    .top_lvl   (top_lvl)
  );

  always_comb begin
    req_ld = raise || grant;
    req_d  = req_q;
    idx_d  = idx_q;
    lvl_d  = lvl_q;
    if (raise) begin
      req_d = 1'b1;
      idx_d = win_idx;
      lvl_d = win_lvl;
    end else if (grant) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else if (req_ld) begin
      req_q <= req_d;
      idx_q <= idx_d;
      lvl_q <= lvl_d;
    end
  end

  assign vec_req = req_q;
  assign vec_idx = idx_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec_req && !vec_ack) |=> (vec_req && $stable(vec_idx))); // R7
  AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec_req && vec_ack) |=> !vec_req); // R7
  AST_PREEMPT_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_req |-> (!top_vld || (lvl_q > top_lvl))); // R6
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(vec_req) |-> $past(glb_en)); // R3
endmodule

// File: tb/test_irq_nest_arb.sv
module test_irq_nest_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [6:0] src_req = 7'h00;
  logic       vec_ack = 1'b0;
  logic       reti = 1'b0;
  logic       vec_req;
  logic [2:0] vec_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_en;
  logic [6:0] m_lo, m_hi;

  always #2 clk = ~clk;

  irq_nest_arb i_irq_nest_arb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_req(src_req), .vec_ack(vec_ack),
    .reti(reti), .vec_req(vec_req), .vec_idx(vec_idx)
  );

  function automatic int lvl_of(input int i);
    return 2 * int'(m_hi[i]) + int'(m_lo[i]);
  endfunction

  // expected winner from the requirements; 7 means no request; cur=-1 means idle
  function automatic int exp_win(input logic [6:0] req, input int cur);
    int best = -1;
    int bi = 7;
    if (!m_en[7]) return 7;
    for (int i = 0; i < 7; i++) begin
      if (req[i] && m_en[i] && lvl_of(i) > cur && lvl_of(i) > best) begin
        best = lvl_of(i);
        bi = i;
      end
    end
    return bi;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s == 2'd0) m_en = d;
    if (s == 2'd1) m_lo = d[6:0];
    if (s == 2'd2) m_hi = d[6:0];
  endtask

  task automatic check(input int exp, input string tag);
    n_chk++;
    if (exp == 7) begin
      if (vec_req !== 1'b0) begin
        n_fail++;
        $display("FAIL %s: vec_req=%b vec_idx=%0d, expected no request", tag, vec_req, vec_idx);
      end
    end else if (vec_req !== 1'b1 || vec_idx !== 3'(exp)) begin
      n_fail++;
      $display("FAIL %s: vec_req=%b vec_idx=%0d, expected request idx %0d", tag, vec_req, vec_idx, exp);
    end
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    vec_ack = 1'b1; src_req = 7'h00;
    @(negedge clk);
    vec_ack = 1'b0;
  endtask

  task automatic reti_pulse();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  // raise and acknowledge one source to enter its level
  task automatic enter(input int i, input string tag);
    src_req = 7'(1 << i);
    @(negedge clk);
    check(i, tag);
    ack_pulse();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    m_en = 8'h00; m_lo = 7'h00; m_hi = 7'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reset state, every source asserted
    src_req = 7'h7F;
    @(negedge clk); @(negedge clk);
    check(7, "R2 reset");
    src_req = 7'h00;

    // R3: gate clear blocks all; R1 per-source bit positions
    wr(2'd0, 8'h7F);
    src_req = 7'h7F;
    @(negedge clk); @(negedge clk);
    check(7, "R3 global gate clear");
    src_req = 7'h00;
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'h80 | 8'(1 << i));
      src_req = 7'h7F;
      @(negedge clk);
      check(exp_win(7'h7F, -1), "R1 R3 single enable");
      ack_pulse();
      reti_pulse();
      wr(2'd0, 8'h80 | (8'h7F & ~8'(1 << i)));
      src_req = 7'(1 << i);
      @(negedge clk); @(negedge clk);
      check(7, "R3 own enable clear");
      src_req = 7'h00;
    end

    // R4 R5: all request patterns under several priority maps
    wr(2'd0, 8'hFF);
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: begin wr(2'd1, 8'h00); wr(2'd2, 8'h00); end
        1: begin wr(2'd1, 8'h33); wr(2'd2, 8'h0F); end
        2: begin wr(2'd1, 8'h2A); wr(2'd2, 8'h70); end
        default: begin wr(2'd1, 8'h6C); wr(2'd2, 8'h15); end
      endcase
      for (int p = 1; p < 128; p++) begin
        src_req = 7'(p);
        @(negedge clk);
        check(exp_win(7'(p), -1), (c == 0) ? "R5 polling order" : "R4 level select");
        ack_pulse();
        reti_pulse();
      end
    end

    // R10: reserved select leaves enables and priorities alone
    wr(2'd1, 8'h00); wr(2'd2, 8'h40);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0;
    src_req = 7'h7F;
    @(negedge clk);
    check(6, "R10 reserved write ignored");
    ack_pulse();
    reti_pulse();

    // R6: levels 0,0,1,1,2,2,3 for sources 0..6
    wr(2'd1, 8'h4C); wr(2'd2, 8'h70);
    for (int l = 0; l < 4; l++) begin
      enter(2 * l, "R6 enter level");
      for (int j = 0; j < 7; j++) begin
        src_req = 7'(1 << j);
        @(negedge clk); @(negedge clk);
        check(exp_win(7'(1 << j), l), "R6 strict preemption");
        if (vec_req) begin
          ack_pulse();
          reti_pulse();
        end
        src_req = 7'h00;
      end
      src_req = 7'h7F;
      @(negedge clk); @(negedge clk);
      check(exp_win(7'h7F, l), "R6 all sources over service level");
      if (vec_req) begin
        ack_pulse();
        reti_pulse();
      end
      src_req = 7'h00;
      reti_pulse();
    end

    // R9: blocked request raised after release
    enter(4, "R9 enter level 2");
    src_req = 7'h04;
    @(negedge clk); @(negedge clk);
    check(7, "R9 blocked while level 2 in service");
    reti_pulse();
    check(7, "R9 no request on release clock");
    @(negedge clk);
    check(2, "R9 raised after release");
    ack_pulse();
    reti_pulse();

    // R7: one-clock latency, held until ack, drop on ack
    src_req = 7'h02;
    check(7, "R7 not yet sampled");
    @(negedge clk);
    check(1, "R7 one clock latency");
    src_req = 7'h40;
    repeat (3) @(negedge clk);
    check(1, "R7 held against higher request");
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    check(7, "R7 drop on ack");
    @(negedge clk);
    check(6, "R7 next winner after ack");
    ack_pulse();
    reti_pulse();
    reti_pulse();

    // R8: return pops only the highest nested level
    enter(2, "R8 enter level 1");
    enter(6, "R8 enter level 3");
    reti_pulse();
    src_req = 7'h08;
    @(negedge clk); @(negedge clk);
    check(7, "R8 level 1 still in service");
    src_req = 7'h10;
    @(negedge clk);
    check(4, "R8 level 3 released");
    ack_pulse();
    reti_pulse();
    reti_pulse();
    src_req = 7'h01;
    @(negedge clk);
    check(0, "R8 all levels released");
    ack_pulse();
    reti_pulse();

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule